// File: doc/BRIEF.md
# Escaped Packet Framing Decoder

This block sits behind a byte-serial receive link and turns a raw physical byte stream back into packet bytes. The stream may carry idle fill bytes at any point, marks packets with start and end symbols, names a channel after a channel symbol, and hides any data byte that collides with a control symbol behind an escape symbol. The decoder strips the fill, resolves the escapes and delivers each recovered data byte on a registered valid interface, with flags for the first and last byte of the packet.

The end of a packet is unusual: the end symbol does not close the packet by itself. It arrives just before the final data byte, and that following data byte is delivered with the last-byte flag. Only channel zero is accepted. A non-zero channel number, or a control symbol in an illegal position, raises a one-cycle error pulse. The decoder then discards input until the next start symbol. A fresh start symbol inside a packet abandons the partial packet and begins a new one.

Top module: `pkt_frame_decoder`

## Requirements
- R1: During and right after the synchronous active-high reset, `out_valid` and `out_err` are low.
- R2: While no packet is open (after reset, after a completed packet, or after an error), every byte other than the start symbol 0x7A is discarded without output or error.
- R3: The idle byte 0x4A is dropped in every position, including between an escape and its data byte and between the channel symbol and the channel number, and it does not change the decoder state.
- R4: A start symbol 0x7A inside an open packet abandons the partial packet, and the next data byte is delivered as a first byte.
- R5: The byte after the channel symbol 0x7C is the channel number. A value of zero is consumed without output, and any non-zero value is a framing error.
- R6: Either 0x7D or 0x4D is an escape: it produces no output, and the next data byte is delivered XORed with 0x20.
- R7: An escape followed by another escape (0x7D or 0x4D), by an end symbol 0x7B or by a channel symbol 0x7C is a framing error.
- R8: An end symbol 0x7B or a channel symbol 0x7C arriving after an end symbol of the same packet is a framing error.
- R9: The first data byte after the end symbol is delivered with `out_eop` high, and it closes the packet.
- R10: The first data byte delivered after a start symbol has `out_sop` high, and no later byte of that packet has it.
- R11: A framing error raises `out_err` for exactly one cycle, produces no data, and closes the packet, so bytes up to the next 0x7A are dropped.
- R12: An output appears in the cycle after its input byte is accepted. A cycle without an accepted byte is followed by a cycle with `out_valid` and `out_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Physical stream byte |
| out_valid | output | 1 | Recovered data byte is valid |
| out_data | output | 8 | Recovered data byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_err | output | 1 | One-cycle framing error pulse |

## Verification
The hardest situations to reach are ones where a control symbol lands in a state that exists for only one byte. Examples are an escape directly followed by an end or channel symbol, and an idle byte wedged between an escape and its target. The stimulus reaches them with hand-built streams. Each stream opens a packet and places the offending symbol at exactly that position, so every escape-ordering violation is reached in turn. Idle bytes are also sprinkled into those same gaps. After each error, bytes that would be legal inside a packet are sent before the next start symbol, which shows that the decoder is really hunting.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYM_START = 8'h7A;
  localparam logic [BYTE_W-1:0] SYM_END   = 8'h7B;
  localparam logic [BYTE_W-1:0] SYM_CHAN  = 8'h7C;
  localparam logic [BYTE_W-1:0] SYM_ESC_A = 8'h7D;
  localparam logic [BYTE_W-1:0] SYM_ESC_B = 8'h4D;
  localparam logic [BYTE_W-1:0] SYM_IDLE  = 8'h4A;
  localparam logic [BYTE_W-1:0] ESC_MASK  = 8'h20;

  typedef enum logic [2:0] {
    CL_DATA,
    CL_IDLE,
    CL_START,
    CL_END,
    CL_CHAN,
    CL_ESC
  } sym_cls_e;
endpackage

// File: rtl/pkt_dec_classify.sv
module pkt_dec_classify
  import pkt_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] sym,
  output sym_cls_e          cls
);
  always_comb begin
    case (sym)
      SYM_IDLE:             cls = CL_IDLE;
      SYM_START:            cls = CL_START;
      SYM_END:              cls = CL_END;
      SYM_CHAN:             cls = CL_CHAN;
      SYM_ESC_A, SYM_ESC_B: cls = CL_ESC;
      default:              cls = CL_DATA;
    endcase
  end
endmodule

// File: rtl/pkt_dec_fsm.sv
module pkt_dec_fsm
  import pkt_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  sym_cls_e          cls,
  output logic              emit,
  output logic [BYTE_W-1:0] emit_data,
  output logic              emit_sop,
  output logic              emit_eop,
  output logic              frame_err,
  output logic              pkt_open
);
  logic open_q, chan_q, esc_q, end_q, first_q;
  logic open_n, chan_n, esc_n, end_n, first_n;

  assign pkt_open = open_q;

  always_comb begin
    open_n    = open_q;
    chan_n    = chan_q;
    esc_n     = esc_q;
    end_n     = end_q;
    first_n   = first_q;
    emit      = 1'b0;
    frame_err = 1'b0;
    emit_data = esc_q ? (in_data ^ ESC_MASK) : in_data;
    emit_sop  = first_q;
    emit_eop  = end_q;
    if (in_valid && cls != CL_IDLE) begin
      if (!open_q) begin
        if (cls == CL_START) begin
          open_n = 1'b1; first_n = 1'b1;
          chan_n = 1'b0; esc_n = 1'b0; end_n = 1'b0;
        end
      end else if (chan_q) begin
        if (in_data != '0) frame_err = 1'b1;
        else               chan_n    = 1'b0;
      end else begin
        case (cls)
          CL_START: begin
            first_n = 1'b1;
            chan_n = 1'b0; esc_n = 1'b0; end_n = 1'b0;
          end
          CL_END: begin
            if (esc_q || end_q) frame_err = 1'b1;
            else                end_n     = 1'b1;
          end
          CL_CHAN: begin
            if (esc_q || end_q) frame_err = 1'b1;
            else                chan_n    = 1'b1;
          end
          CL_ESC: begin
            if (esc_q) frame_err = 1'b1;
            else       esc_n     = 1'b1;
          end
          default: begin
            emit    = 1'b1;
            esc_n   = 1'b0;
            first_n = 1'b0;
            if (end_q) begin
              open_n = 1'b0;
              end_n  = 1'b0;
            end
          end
        endcase
      end
      if (frame_err) begin
        open_n = 1'b0; chan_n = 1'b0; esc_n = 1'b0;
        end_n = 1'b0; first_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      chan_q  <= 1'b0;
      esc_q   <= 1'b0;
      end_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      open_q  <= open_n;
      chan_q  <= chan_n;
      esc_q   <= esc_n;
      end_q   <= end_n;
      first_q <= first_n;
    end
  end
endmodule

// File: rtl/pkt_dec_outreg.sv
module pkt_dec_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         emit,
  input  logic [W-1:0] emit_data,
  input  logic         emit_sop,
  input  logic         emit_eop,
  input  logic         frame_err,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_sop,
  output logic         out_eop,
  output logic         out_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= emit;
      out_sop   <= emit & emit_sop;
      out_eop   <= emit & emit_eop;
      out_err   <= frame_err;
      if (emit) out_data <= emit_data;
    end
  end
endmodule

// File: rtl/pkt_frame_decoder.sv
module pkt_frame_decoder
  import pkt_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err
);
  sym_cls_e          cls;
  logic              emit, emit_sop, emit_eop, frame_err, pkt_open;
  logic [BYTE_W-1:0] emit_data;

  pkt_dec_classify u_cls (
    .sym (in_data),
    .cls (cls)
  );

  pkt_dec_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cls       (cls),
    .emit      (emit),
    .emit_data (emit_data),
    .emit_sop  (emit_sop),
    .emit_eop  (emit_eop),
    .frame_err (frame_err),
    .pkt_open  (pkt_open)
  );

  pkt_dec_outreg #(.W(BYTE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .emit_data (emit_data),
    .emit_sop  (emit_sop),
    .emit_eop  (emit_eop),
    .frame_err (frame_err),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err)
  );
endmodule

// File: rtl/pkt_frame_decoder_chk.sv
module pkt_frame_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic       out_err,
  input logic       pkt_open
);
  // R12: nothing accepted means nothing delivered next cycle
  a_r12_quiet_after_gap: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_err));

  // R3: idle byte never yields data or error
  a_r3_idle_dropped: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == 8'h4A) |=> (!out_valid && !out_err));

  // R2: hunting discards all but the start symbol
  a_r2_hunt_discard: assert property (@(posedge clk) disable iff (rst)
    (!pkt_open && in_valid && in_data != 8'h7A) |=> (!out_valid && !out_err));

  // R11: an error carries no data and leaves the packet closed
  a_r11_err_closes: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (!out_valid && !pkt_open));

  // R9: last byte closes the packet
  a_r9_eop_closes: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> (out_valid && !pkt_open));

  // R10: first-byte flag only on delivered data
  a_r10_sop_valid: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);
endmodule

bind pkt_frame_decoder pkt_frame_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_err   (out_err),
  .pkt_open  (pkt_open)
);

// File: tb/sim_pkt_frame_decoder.sv
`timescale 1ns/1ps
module sim_pkt_frame_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_sop, out_eop, out_err;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int  phase = 0;        // 0 hunting, 1 in packet, 2 awaiting channel number
  bit  saw_esc = 1'b0;
  bit  saw_end = 1'b0;
  bit  want_sop = 1'b0;
  bit       ev, es, ee, er;
  bit [7:0] ed;

  always #2 clk = ~clk;

  pkt_frame_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err)
  );

  task automatic model(input bit v, input bit [7:0] b);
    ev = 0; es = 0; ee = 0; er = 0; ed = 8'h00;
    if (!v || b == 8'h4A) return;
    if (phase == 0) begin
      if (b == 8'h7A) begin phase = 1; saw_esc = 0; saw_end = 0; want_sop = 1; end
      return;
    end
    if (phase == 2) begin
      if (b != 8'h00) begin er = 1; phase = 0; end
      else phase = 1;
      return;
    end
    if (b == 8'h7A) begin saw_esc = 0; saw_end = 0; want_sop = 1; return; end
    if (b == 8'h7B || b == 8'h7C) begin
      if (saw_esc || saw_end) begin er = 1; phase = 0; end
      else if (b == 8'h7B) saw_end = 1;
      else phase = 2;
      return;
    end
    if (b == 8'h7D || b == 8'h4D) begin
      if (saw_esc) begin er = 1; phase = 0; end
      else saw_esc = 1;
      return;
    end
    ev = 1;
    ed = saw_esc ? (b ^ 8'h20) : b;
    es = want_sop;
    ee = saw_end;
    saw_esc = 0;
    want_sop = 0;
    if (saw_end) begin phase = 0; saw_end = 0; end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== ev || out_err !== er || out_sop !== es || out_eop !== ee ||
        (ev && out_data !== ed)) begin
      fails++;
      $display("FAIL %s: got v=%0b d=%h sop=%0b eop=%0b err=%0b expected v=%0b d=%h sop=%0b eop=%0b err=%0b",
               tag, out_valid, out_data, out_sop, out_eop, out_err, ev, ed, es, ee, er);
    end
  endtask

  // called at a negedge; leaves at the next negedge after checking
  task automatic push(input bit v, input bit [7:0] b, input string tag);
    in_valid = v;
    in_data  = b;
    model(v, b);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic feed(input bit [7:0] s[], input string tag);
    foreach (s[i]) push(1'b1, s[i], tag);
    push(1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    ev = 0; es = 0; ee = 0; er = 0;
    compare("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    compare("R1 after reset");

    feed('{8'h11, 8'h7B, 8'h7C, 8'h55, 8'h7D, 8'h00}, "R2 pre-start discard");
    feed('{8'h7A, 8'h7C, 8'h00, 8'h10, 8'h20, 8'h7B, 8'h30}, "R10 R9 basic packet");
    feed('{8'h44, 8'h7B, 8'h7C, 8'h66}, "R9 R2 hunt after eop");
    feed('{8'h7A, 8'h7C, 8'h00, 8'h7D, 8'h5A, 8'h4D, 8'h6A, 8'h7B, 8'h7D, 8'h5B}, "R6 escapes");
    feed('{8'h4A, 8'h7A, 8'h4A, 8'h7C, 8'h4A, 8'h00, 8'h4A, 8'h7D, 8'h4A, 8'h5D,
           8'h01, 8'h4A, 8'h7B, 8'h4A, 8'h02}, "R3 idle fill");
    feed('{8'h7A, 8'h7C, 8'h00, 8'h01, 8'h02, 8'h7A, 8'h7C, 8'h00, 8'h03, 8'h7B, 8'h04}, "R4 restart");
    feed('{8'h7A, 8'h7C, 8'h05, 8'h11, 8'h7B, 8'h12}, "R5 R11 bad channel");
    feed('{8'h7A, 8'h7C, 8'h00, 8'h22, 8'h7B, 8'h33}, "R5 channel zero");
    feed('{8'h7A, 8'h7D, 8'h7D, 8'h01}, "R7 esc esc");
    feed('{8'h7A, 8'h7D, 8'h7B, 8'h02}, "R7 esc end");
    feed('{8'h7A, 8'h4D, 8'h7C, 8'h03}, "R7 esc chan");
    feed('{8'h7A, 8'h4D, 8'h7D, 8'h04}, "R7 alt esc esc");
    feed('{8'h7A, 8'h01, 8'h7B, 8'h7B, 8'h05, 8'h7B, 8'h06}, "R8 end end");
    feed('{8'h7A, 8'h01, 8'h7B, 8'h7C, 8'h00, 8'h07}, "R8 end chan");
    feed('{8'h55, 8'h7B, 8'h08, 8'h7A, 8'h09, 8'h7B, 8'h0A}, "R11 recovery");
    push(1'b1, 8'h7A, "R12 gaps");
    push(1'b0, 8'h41, "R12 gaps");
    push(1'b1, 8'h41, "R12 gaps");
    push(1'b0, 8'h7B, "R12 gaps");
    push(1'b1, 8'h42, "R12 gaps");
    push(1'b0, 8'h00, "R12 gaps");
    push(1'b1, 8'h7B, "R12 gaps");
    push(1'b1, 8'h43, "R12 gaps");
    push(1'b0, 8'h00, "R12 gaps");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule